// File: doc/BRIEF.md
# Glitch-Free PLL Bypass Switch

This block chooses the source of the derived clock, either the reference input or the PLL output. It never switches with the derived clock running. Each change of source is wrapped in a gated window, counted in reference cycles. The window is asymmetric: leaving the PLL takes a longer gap than returning to it. The source indication changes only in the second or a later gated cycle. All control logic runs on the reference clock. The PLL is modelled as an ideal clock input, and clock division is left to downstream logic.

Software requests bypass through a level input. That input is captured by a synchronizer on the reference domain. A one-cycle reprogram strobe runs a full frequency-change sequence. The switch moves to the reference clock and raises a one-cycle load pulse so the PLL takes its new settings. It then waits a programmed number of reference cycles for lock and raises a one-cycle lock-done wakeup pulse. Finally it returns to the PLL, unless bypass is requested at that moment. Seen from the PLL side, a frequency change costs the lock count plus six reference cycles.

There is no data stream, so there is no valid/ready interface. Every pin is a plain control or status level, or a one-cycle pulse.

Top module: `pll_bypass_switch`

## Requirements
- R1: While reset is asserted and right after it, `drv_en` is 1, `src_pll` is 0 (reference selected), and `lock_done` and `pll_cfg_load` are 0.
- R2: `bypass_req` passes through a two-flop synchronizer on `clk_ref`. When the switch runs on the PLL and the request rises, `drv_en` is still 1 after the second rising edge and is 0 after the third.
- R3: A switch from PLL to reference holds `drv_en` at 0 for exactly REF_GAP reference cycles (default 4).
- R4: A switch from reference to PLL holds `drv_en` at 0 for exactly PLL_GAP reference cycles (default 2). With bypass released, the switch settles on the PLL (`src_pll` = 1).
- R5: `src_pll` changes only in a cycle where `drv_en` is 0 and was also 0 in the previous cycle.
- R6: `drv_clk` equals `clk_pll` when `drv_en`=1 and `src_pll`=1. It equals `clk_ref` when `drv_en`=1 and `src_pll`=0. It is 0 when `drv_en`=0.
- R7: A reprogram strobe accepted on the PLL runs this sequence: the REF_GAP gated cycles, then the lock wait on the reference clock (`drv_en`=1, `src_pll`=0), then the PLL_GAP gated cycles. `pll_cfg_load` pulses once, in the first lock-wait cycle. For a lock count N ≥ 1, the output is away from the PLL for N+6 cycles in total.
- R8: The lock wait lasts N reference cycles, and `lock_done` pulses once, in its last cycle. A lock count of 0 behaves like 1, so the wakeup comes in the first lock-wait cycle.
- R9: A reprogram strobe accepted while on the reference clock enters the lock wait at once, with no gated cycles. The switch stays on the reference clock if bypass is still requested when the lock wait ends.
- R10: A reprogram strobe that arrives during a gated window or during the lock wait is ignored. There is no second load pulse, no second wakeup, and no change to the timing.
- R11: `lock_cnt` is captured only when a strobe is accepted. Changing it during the lock wait does not change the wait length.
- R12: If bypass is requested when the lock wait ends, the switch stays on the reference clock and skips the PLL_GAP window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock; clocks all control logic |
| clk_pll | input | 1 | PLL output clock (ideal model) |
| rst_n | input | 1 | Asynchronous active-low reset |
| bypass_req | input | 1 | Level request to run from the reference clock (asynchronous) |
| reprog_stb | input | 1 | One-cycle strobe on `clk_ref` that starts a frequency change |
| lock_cnt | input | LOCK_W | Lock wait length in reference cycles, captured on an accepted strobe |
| drv_en | output | 1 | Derived clock enable; 0 while the source is being switched |
| src_pll | output | 1 | Selected source: 1 = PLL, 0 = reference |
| drv_clk | output | 1 | Gated, selected derived clock |
| lock_done | output | 1 | One-cycle wakeup pulse at the end of the lock wait |
| pll_cfg_load | output | 1 | One-cycle pulse telling the PLL to apply its new settings |

## Verification
The checker tests four things every cycle. The source flag moves only deep inside a gated window. Every gated window has the length that matches the direction it ends in. The load and wakeup pulses last one cycle and occur only while the reference clock drives the output. The bench covers what a single-cycle property cannot express: the synchronizer latency, the N+6 total cost, and the handling of a zero lock count. It also shows that strobes and lock-count changes during a sequence are ignored, and that a bypass request arriving mid-lock keeps the switch on the reference clock.

// File: rtl/pbs_pkg.sv
package pbs_pkg;

  typedef enum logic [2:0] {
    ST_RUN_REF  = 3'd0,
    ST_RUN_PLL  = 3'd1,
    ST_GAP_REF  = 3'd2,
    ST_GAP_PLL  = 3'd3,
    ST_LOCK     = 3'd4
  } pbs_state_e;

  function automatic int unsigned pbs_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pbs_sync.sv
module pbs_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= RST_VAL;
          else        chain_q[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= RST_VAL;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/pbs_lock_timer.sv
module pbs_lock_timer #(
  parameter int LOCK_W   = 16,
  parameter int DEF_LOCK = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic [LOCK_W-1:0] limit_in,
  input  logic              start,
  input  logic              run,
  output logic              hit,
  output logic              first
);

  localparam logic [LOCK_W-1:0] CNT_ONE = LOCK_W'(1);
  localparam logic [LOCK_W-1:0] CNT_MAX = {LOCK_W{1'b1}};

  logic [LOCK_W-1:0] lim_q;
  logic [LOCK_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_q <= LOCK_W'(DEF_LOCK);
    end else if (arm) begin
      lim_q <= limit_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (start) begin
      cnt_q <= CNT_ONE;
    end else if (run && (cnt_q != CNT_MAX)) begin
      cnt_q <= cnt_q + CNT_ONE;
    end
  end

  assign hit   = run && (cnt_q >= lim_q);
  assign first = run && (cnt_q == CNT_ONE);

endmodule

// File: rtl/pbs_seq.sv
module pbs_seq
  import pbs_pkg::*;
#(
  parameter int REF_GAP = 4,
  parameter int PLL_GAP = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic byp_s,
  input  logic reprog_stb,
  input  logic lock_hit,
  output logic arm,
  output logic lock_start,
  output logic lock_run,
  output logic en,
  output logic sel_pll
);

  localparam int GW = $clog2(pbs_max(REF_GAP, PLL_GAP)) + 1;
  localparam logic [GW-1:0] REF_LAST = GW'(REF_GAP - 1);
  localparam logic [GW-1:0] PLL_LAST = GW'(PLL_GAP - 1);
  localparam logic [GW-1:0] GAP_ONE  = GW'(1);

  pbs_state_e    st_q, st_n;
  logic [GW-1:0] gap_q, gap_n;
  logic          sel_q, sel_n;
  logic          relock_q, relock_n;

  always_comb begin
    st_n       = st_q;
    gap_n      = gap_q;
    sel_n      = sel_q;
    relock_n   = relock_q;
    arm        = 1'b0;
    lock_start = 1'b0;
    unique case (st_q)
      ST_RUN_PLL: begin
        if (reprog_stb) begin
          st_n     = ST_GAP_REF;
          gap_n    = '0;
          relock_n = 1'b1;
          arm      = 1'b1;
        end else if (byp_s) begin
          st_n     = ST_GAP_REF;
          gap_n    = '0;
          relock_n = 1'b0;
        end
      end
      ST_RUN_REF: begin
        if (reprog_stb) begin
          st_n       = ST_LOCK;
          arm        = 1'b1;
          lock_start = 1'b1;
        end else if (!byp_s) begin
          st_n  = ST_GAP_PLL;
          gap_n = '0;
        end
      end
      ST_GAP_REF: begin
        if (gap_q == '0) sel_n = 1'b0;
        if (gap_q == REF_LAST) begin
          st_n       = relock_q ? ST_LOCK : ST_RUN_REF;
          lock_start = relock_q;
          relock_n   = 1'b0;
        end else begin
          gap_n = gap_q + GAP_ONE;
        end
      end
      ST_GAP_PLL: begin
        if (gap_q == '0) sel_n = 1'b1;
        if (gap_q == PLL_LAST) begin
          st_n = ST_RUN_PLL;
        end else begin
          gap_n = gap_q + GAP_ONE;
        end
      end
      ST_LOCK: begin
        if (lock_hit) begin
          st_n  = byp_s ? ST_RUN_REF : ST_GAP_PLL;
          gap_n = '0;
        end
      end
      default: begin
        st_n  = ST_RUN_REF;
        sel_n = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_RUN_REF;
      gap_q    <= '0;
      sel_q    <= 1'b0;
      relock_q <= 1'b0;
    end else begin
      st_q     <= st_n;
      gap_q    <= gap_n;
      sel_q    <= sel_n;
      relock_q <= relock_n;
    end
  end

  assign lock_run = (st_q == ST_LOCK);
  assign en       = (st_q == ST_RUN_REF) || (st_q == ST_RUN_PLL) || (st_q == ST_LOCK);
  assign sel_pll  = sel_q;

endmodule

// File: rtl/pbs_clk_mux.sv
module pbs_clk_mux (
  input  logic clk_ref,
  input  logic clk_pll,
  input  logic en,
  input  logic sel_pll,
  output logic clk_out
);

  logic picked;

  always_comb begin
    picked  = sel_pll ? clk_pll : clk_ref;
    clk_out = en & picked;
  end

endmodule

// File: rtl/pll_bypass_switch.sv
module pll_bypass_switch #(
  parameter int LOCK_W      = 16,
  parameter int DEF_LOCK    = 512,
  parameter int REF_GAP     = 4,
  parameter int PLL_GAP     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_ref,
  input  logic              clk_pll,
  input  logic              rst_n,
  input  logic              bypass_req,
  input  logic              reprog_stb,
  input  logic [LOCK_W-1:0] lock_cnt,
  output logic              drv_en,
  output logic              src_pll,
  output logic              drv_clk,
  output logic              lock_done,
  output logic              pll_cfg_load
);

  logic byp_s;
  logic arm, lock_start, lock_run, lock_hit, lock_first;

  initial begin
    if (REF_GAP < 2 || PLL_GAP < 2 || SYNC_STAGES < 2) begin
      $error("pll_bypass_switch: gaps and synchronizer depth must be at least 2");
    end
  end

  pbs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk   (clk_ref),
    .rst_n (rst_n),
    .d     (bypass_req),
    .q     (byp_s)
  );

  pbs_seq #(.REF_GAP(REF_GAP), .PLL_GAP(PLL_GAP)) u_seq (
    .clk        (clk_ref),
    .rst_n      (rst_n),
    .byp_s      (byp_s),
    .reprog_stb (reprog_stb),
    .lock_hit   (lock_hit),
    .arm        (arm),
    .lock_start (lock_start),
    .lock_run   (lock_run),
    .en         (drv_en),
    .sel_pll    (src_pll)
  );

  pbs_lock_timer #(.LOCK_W(LOCK_W), .DEF_LOCK(DEF_LOCK)) u_lock (
    .clk      (clk_ref),
    .rst_n    (rst_n),
    .arm      (arm),
    .limit_in (lock_cnt),
    .start    (lock_start),
    .run      (lock_run),
    .hit      (lock_hit),
    .first    (lock_first)
  );

  pbs_clk_mux u_mux (
    .clk_ref (clk_ref),
    .clk_pll (clk_pll),
    .en      (drv_en),
    .sel_pll (src_pll),
    .clk_out (drv_clk)
  );

  assign lock_done    = lock_hit;
  assign pll_cfg_load = lock_first;

endmodule

// File: rtl/pbs_checker.sv
module pbs_checker #(
  parameter int REF_GAP = 4,
  parameter int PLL_GAP = 2
) (
  input logic clk_ref,
  input logic rst_n,
  input logic drv_en,
  input logic src_pll,
  input logic lock_done,
  input logic pll_cfg_load
);

  logic [7:0] off_cnt;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n)             off_cnt <= '0;
    else if (drv_en)        off_cnt <= '0;
    else if (off_cnt != '1) off_cnt <= off_cnt + 8'd1;
  end

  // R5: source flag moves only deep inside a gated window
  p_switch_gated_r5: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (src_pll != $past(src_pll)) |-> (!drv_en && !$past(drv_en)));

  // R3 and R4: gated window length depends on direction
  p_gap_len_r3: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(drv_en) |-> (off_cnt == (src_pll ? 8'(PLL_GAP) : 8'(REF_GAP))));

  p_wake_single_r8: assert property (@(posedge clk_ref) disable iff (!rst_n)
    lock_done |=> !lock_done);

  p_wake_on_ref_r7: assert property (@(posedge clk_ref) disable iff (!rst_n)
    lock_done |-> (drv_en && !src_pll));

  p_load_on_ref_r7: assert property (@(posedge clk_ref) disable iff (!rst_n)
    pll_cfg_load |-> (drv_en && !src_pll));

  p_load_single_r10: assert property (@(posedge clk_ref) disable iff (!rst_n)
    pll_cfg_load |=> !pll_cfg_load);

endmodule

bind pll_bypass_switch pbs_checker #(.REF_GAP(REF_GAP), .PLL_GAP(PLL_GAP)) u_pbs_chk (
  .clk_ref      (clk_ref),
  .rst_n        (rst_n),
  .drv_en       (drv_en),
  .src_pll      (src_pll),
  .lock_done    (lock_done),
  .pll_cfg_load (pll_cfg_load)
);

// File: tb/test_pll_bypass_switch.sv
`timescale 1ns/1ps
module test_pll_bypass_switch;

  localparam int REF_PERIOD = 10;
  localparam int PLL_PERIOD = 8;
  localparam int LOCK_W     = 16;
  localparam int NV         = 9;

  // kind (0 bypass level, 1 reprogram), arg, gated, lock len (-1 skip),
  // final src, wake pulses, cycles away from PLL (-1 skip)
  localparam int VEC [0:NV-1][0:6] = '{
    '{0, 1,   4,  -1, 0, 0,  -1},
    '{0, 0,   2,  -1, 1, 0,  -1},
    '{1, 5,   6,   5, 1, 1,  11},
    '{1, 0,   6,   1, 1, 1,   7},
    '{0, 1,   4,  -1, 0, 0,  -1},
    '{1, 3,   0,   3, 0, 1,  -1},
    '{0, 0,   2,  -1, 1, 0,  -1},
    '{1, 1,   6,   1, 1, 1,   7},
    '{1, 512, 6, 512, 1, 1, 518}
  };

  logic clk_ref = 1'b0;
  logic clk_pll = 1'b0;
  logic rst_n;
  logic bypass_req;
  logic reprog_stb;
  logic [LOCK_W-1:0] lock_cnt;
  logic drv_en, src_pll, drv_clk, lock_done, pll_cfg_load;

  int n_chk = 0;
  int n_bad = 0;
  bit done_flag = 0;

  int cyc, gated, outc, cfgs, pulses, glitches, cfg_idx, done_idx;
  logic prev_src, prev_en;
  bit mon_on = 0;

  always #(REF_PERIOD/2) clk_ref = ~clk_ref;
  always #(PLL_PERIOD/2) clk_pll = ~clk_pll;

  pll_bypass_switch #(.LOCK_W(LOCK_W)) i_pll_bypass_switch (
    .clk_ref      (clk_ref),
    .clk_pll      (clk_pll),
    .rst_n        (rst_n),
    .bypass_req   (bypass_req),
    .reprog_stb   (reprog_stb),
    .lock_cnt     (lock_cnt),
    .drv_en       (drv_en),
    .src_pll      (src_pll),
    .drv_clk      (drv_clk),
    .lock_done    (lock_done),
    .pll_cfg_load (pll_cfg_load)
  );

  always @(negedge clk_ref) begin
    if (mon_on) begin
      cyc = cyc + 1;
      if (!drv_en) gated = gated + 1;
      if (!(drv_en && src_pll)) outc = outc + 1;
      if (pll_cfg_load) begin cfgs = cfgs + 1; cfg_idx = cyc; end
      if (lock_done) begin pulses = pulses + 1; done_idx = cyc; end
      if ((src_pll != prev_src) && (drv_en || prev_en)) glitches = glitches + 1;
      prev_src = src_pll;
      prev_en  = drv_en;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    cyc = 0; gated = 0; outc = 0; cfgs = 0; pulses = 0; glitches = 0;
    cfg_idx = 0; done_idx = 0;
    prev_src = src_pll; prev_en = drv_en;
    mon_on = 1;
  endtask

  task automatic strobe(input int n);
    @(negedge clk_ref); #1;
    lock_cnt = LOCK_W'(n);
    reprog_stb = 1'b1;
    @(negedge clk_ref); #1;
    reprog_stb = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk_ref);
    #1;
  endtask

  task automatic clk_follow(input string req);
    int bad = 0;
    for (int k = 0; k < 40; k++) begin
      #1;
      if (($time % 4 != 0) && ($time % 5 != 0)) begin
        if (drv_clk !== (drv_en & (src_pll ? clk_pll : clk_ref))) bad++;
      end
    end
    chk(req, bad, 0);
  endtask

  initial begin
    rst_n = 1'b0; bypass_req = 1'b0; reprog_stb = 1'b0; lock_cnt = '0;
    repeat (3) @(negedge clk_ref);
    // R1 reset state
    chk("R1 en", int'(drv_en), 1);
    chk("R1 src", int'(src_pll), 0);
    chk("R1 wake", int'(lock_done), 0);
    chk("R1 load", int'(pll_cfg_load), 0);
    #1; rst_n = 1'b1;
    settle(20);
    chk("R4 settle on pll", int'(src_pll), 1);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk_ref); #1;
      clear_mon();
      if (VEC[i][0] == 0) begin
        bypass_req = VEC[i][1][0];
        settle(30);
      end else begin
        lock_cnt   = LOCK_W'(VEC[i][1]);
        reprog_stb = 1'b1;
        @(negedge clk_ref); #1;
        reprog_stb = 1'b0;
        settle(30 + VEC[i][1]);
      end
      chk($sformatf("R3 R4 vec%0d gated", i), gated, VEC[i][2]);
      chk($sformatf("R5 vec%0d glitch", i), glitches, 0);
      chk($sformatf("R7 vec%0d src", i), int'(src_pll), VEC[i][4]);
      chk($sformatf("R8 vec%0d pulses", i), pulses, VEC[i][5]);
      chk($sformatf("R7 vec%0d load", i), cfgs, VEC[i][5]);
      if (VEC[i][3] >= 0) chk($sformatf("R8 R9 vec%0d lock", i), done_idx - cfg_idx + 1, VEC[i][3]);
      if (VEC[i][6] >= 0) chk($sformatf("R7 vec%0d total", i), outc, VEC[i][6]);
    end

    // R6 clock follows PLL
    clk_follow("R6 pll");

    // R2 synchronizer latency
    @(negedge clk_ref); #1;
    bypass_req = 1'b1;
    @(negedge clk_ref);
    @(negedge clk_ref); #1;
    chk("R2 en after 2 edges", int'(drv_en), 1);
    @(negedge clk_ref); #1;
    chk("R2 en after 3 edges", int'(drv_en), 0);
    settle(20);
    chk("R3 on ref", int'(src_pll), 0);
    clk_follow("R6 ref");
    bypass_req = 1'b0;
    settle(20);

    // R10 R11: strobes in gap and lock ignored, lock count change ignored
    @(negedge clk_ref); #1;
    clear_mon();
    lock_cnt = 16'd8; reprog_stb = 1'b1;
    @(negedge clk_ref); #1; reprog_stb = 1'b0;
    @(negedge clk_ref); #1; reprog_stb = 1'b1;
    @(negedge clk_ref); #1; reprog_stb = 1'b0;
    repeat (3) @(negedge clk_ref);
    #1; lock_cnt = 16'd3; reprog_stb = 1'b1;
    @(negedge clk_ref); #1; reprog_stb = 1'b0;
    settle(40);
    chk("R10 pulses", pulses, 1);
    chk("R10 loads", cfgs, 1);
    chk("R10 gated", gated, 6);
    chk("R11 lock len", done_idx - cfg_idx + 1, 8);

    // R12: bypass raised during lock wait
    @(negedge clk_ref); #1;
    clear_mon();
    strobe(10);
    repeat (6) @(negedge clk_ref);
    #1; bypass_req = 1'b1;
    settle(40);
    chk("R12 src", int'(src_pll), 0);
    chk("R12 gated", gated, 4);
    chk("R12 pulses", pulses, 1);
    mon_on = 0;

    // R1 reset during lock wait
    bypass_req = 1'b0;
    settle(20);
    strobe(50);
    settle(10);
    rst_n = 1'b0;
    #2;
    chk("R1 mid-lock en", int'(drv_en), 1);
    chk("R1 mid-lock src", int'(src_pll), 0);
    chk("R1 mid-lock wake", int'(lock_done), 0);
    settle(2);
    rst_n = 1'b1;
    settle(5);

    if (!done_flag) begin
      done_flag = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk_ref);
    if (!done_flag) begin
      done_flag = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule